// File: doc/BRIEF.md
# Overlapped Association Query Dispatcher

This block sits in front of a per-packet lookup path. It takes query requests in arrival order and overlaps them with slow main-memory searches. Each request carries an association identifier and a tag chosen by the consumer. The block buffers requests in an input queue and sends the oldest one to an external cache lookup, at most one per cycle. A hit completes at once. A miss joins a pending-miss queue, and that queue feeds an external main-memory searcher strictly one search at a time, oldest first.

Completions can leave out of arrival order, because a hit can overtake a miss that is still being searched. The tag on each completion lets the consumer put them back in order. Two identifiers may never be searched at the same time if they are equal. The block therefore compares the identifier at the head of the input queue with the active search and with every queued miss in the same cycle. On a match the head stalls, and everything behind it stalls too, until that search has finished.

Top module: `queryDispatcher`

## Requirements
- R1: After reset, `reqReady` is 1 and `hitDone`, `missDone`, `srchStart` and `cacheLookup` are all 0.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 whenever the input queue is full or the pending-miss queue is full.
- R3: The oldest waiting request is presented on `cacheKey` with `cacheLookup` high, at most one per cycle. Requests issue in arrival order, so back-to-back hits complete on consecutive cycles.
- R4: A hit that arrives behind a request still being searched in main memory completes before that search does.
- R5: Misses start main-memory searches (`srchStart` with `srchId`) in arrival order. A new search starts only when no search is active, so at most one search is ever outstanding.
- R6: One cycle after `srchDone` is sampled high, `missDone` is high for one cycle and `missTag` carries the tag of the request that was searched.
- R7: If the head request's identifier equals the identifier of the active search or of any queued miss, neither that request nor any later one issues until the conflicting search has completed.
- R8: While the pending-miss queue is full, no request issues to the cache, including hits.
- R9: Every accepted request produces exactly one completion, either on `hitDone`/`hitTag` or on `missDone`/`missTag`.
- R10: A hit completion is registered: `hitDone` rises one cycle after the lookup cycle in which `cacheHit` was 1, and `hitTag` carries the request's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqId | input | IdW | Association identifier of the request |
| reqTag | input | TagW | Consumer tag of the request |
| cacheLookup | output | 1 | Cache lookup issued this cycle |
| cacheKey | output | IdW | Identifier being looked up |
| cacheHit | input | 1 | Same-cycle cache answer for `cacheKey` |
| srchStart | output | 1 | Start a main-memory search this cycle |
| srchId | output | IdW | Identifier to search |
| srchDone | input | 1 | Active search finished (one-cycle pulse) |
| hitDone | output | 1 | Completion of a cache hit |
| hitTag | output | TagW | Tag of the hit completion |
| missDone | output | 1 | Completion of a searched miss |
| missTag | output | TagW | Tag of the miss completion |

## Verification
The bench builds the block with an input queue of four entries and a pending-miss queue of only two. With those sizes a handful of misses is enough to fill the miss queue while a 12-cycle search is outstanding, and then to back the input queue up until `reqReady` drops. The 8-bit identifier and 4-bit tag let each scenario give every request its own tag, so that duplicated and missing completions can be told apart. They also leave room for a hit-capable identifier and a miss-only identifier to sit in the same stream.

// File: rtl/qdPkg.sv
package qdPkg;

  // Per-cycle strobes from the control module to the datapath.
  typedef struct packed {
    logic inPush;     // accept a request into the input queue
    logic issue;      // head request looked up in cache, leaves input queue
    logic missPush;   // issued head missed: enqueue pending search
    logic hitLog;     // issued head hit: register a hit completion
    logic missPop;    // oldest pending miss becomes the active search
    logic searchClr;  // active search finished: register miss completion
  } qdStrobe_t;

endpackage

// File: rtl/qdMissQueue.sv
// Pending-miss FIFO. Every valid entry is compared with a probe identifier
// in the same cycle. Depth must be a power of two.
module qdMissQueue #(
  parameter int IdW   = 8,
  parameter int TagW  = 4,
  parameter int Depth = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            push,
  input  logic            pop,
  input  logic [IdW-1:0]  pushId,
  input  logic [TagW-1:0] pushTag,
  input  logic [IdW-1:0]  probeId,
  output logic [IdW-1:0]  headId,
  output logic [TagW-1:0] headTag,
  output logic            empty,
  output logic            full,
  output logic            probeHit
);
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [IdW-1:0]  idMem  [Depth];
  logic [TagW-1:0] tagMem [Depth];
  logic [PtrW-1:0] rdPtr, wrPtr;
  logic [CntW-1:0] count;
  logic [Depth-1:0] matchVec;

  assign empty   = (count == '0);
  assign full    = (count == CntW'(Depth));
  assign headId  = idMem[rdPtr];
  assign headTag = tagMem[rdPtr];

  for (genvar i = 0; i < Depth; i++) begin : g_probe
    logic [PtrW-1:0] offset;
    logic            live;
    assign offset      = PtrW'(i) - rdPtr;
    assign live        = (CntW'(offset) < count);
    assign matchVec[i] = live && (idMem[i] == probeId);
  end

  assign probeHit = |matchVec;

  always_ff @(posedge clk) begin
    if (push) begin
      idMem[wrPtr]  <= pushId;
      tagMem[wrPtr] <= pushTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: never written while full
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push);
  // R5: a search never starts from an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop);

endmodule

// File: rtl/qdData.sv
// Datapath: input queue, pending-miss queue, active search registers,
// in-flight identifier comparison and completion registers.
module qdData
  import qdPkg::*;
#(
  parameter int IdW       = 8,
  parameter int TagW      = 4,
  parameter int InDepth   = 4,
  parameter int MissDepth = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  qdStrobe_t       strb,
  input  logic            activeValid,
  input  logic [IdW-1:0]  reqId,
  input  logic [TagW-1:0] reqTag,
  output logic            inEmpty,
  output logic            inFull,
  output logic            missEmpty,
  output logic            missFull,
  output logic            headConflict,
  output logic [IdW-1:0]  cacheKey,
  output logic [IdW-1:0]  srchId,
  output logic            hitDone,
  output logic [TagW-1:0] hitTag,
  output logic            missDone,
  output logic [TagW-1:0] missTag
);
  localparam int InPtrW = (InDepth > 1) ? $clog2(InDepth) : 1;
  localparam int InCntW = $clog2(InDepth + 1);

  logic [IdW-1:0]    inId  [InDepth];
  logic [TagW-1:0]   inTag [InDepth];
  logic [InPtrW-1:0] inRd, inWr;
  logic [InCntW-1:0] inCnt;
  logic [IdW-1:0]    headId;
  logic [TagW-1:0]   headTag;
  logic [IdW-1:0]    actId;
  logic [TagW-1:0]   actTag;
  logic [IdW-1:0]    missHeadId;
  logic [TagW-1:0]   missHeadTag;
  logic              queuedMatch;

  assign inEmpty  = (inCnt == '0);
  assign inFull   = (inCnt == InCntW'(InDepth));
  assign headId   = inId[inRd];
  assign headTag  = inTag[inRd];
  assign cacheKey = headId;
  assign srchId   = missHeadId;

  always_ff @(posedge clk) begin
    if (strb.inPush) begin
      inId[inWr]  <= reqId;
      inTag[inWr] <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRd  <= '0;
      inWr  <= '0;
      inCnt <= '0;
    end else begin
      if (strb.inPush) inWr <= inWr + 1'b1;
      if (strb.issue)  inRd <= inRd + 1'b1;
      case ({strb.inPush, strb.issue})
        2'b10:   inCnt <= inCnt + 1'b1;
        2'b01:   inCnt <= inCnt - 1'b1;
        default: inCnt <= inCnt;
      endcase
    end
  end

  qdMissQueue #(.IdW(IdW), .TagW(TagW), .Depth(MissDepth)) missQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.missPush),
    .pop      (strb.missPop),
    .pushId   (headId),
    .pushTag  (headTag),
    .probeId  (headId),
    .headId   (missHeadId),
    .headTag  (missHeadTag),
    .empty    (missEmpty),
    .full     (missFull),
    .probeHit (queuedMatch)
  );

  assign headConflict = !inEmpty &&
                        (queuedMatch || (activeValid && (actId == headId)));

  always_ff @(posedge clk) begin
    if (strb.missPop) begin
      actId  <= missHeadId;
      actTag <= missHeadTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitDone  <= 1'b0;
      hitTag   <= '0;
      missDone <= 1'b0;
      missTag  <= '0;
    end else begin
      hitDone  <= strb.hitLog;
      missDone <= strb.searchClr;
      if (strb.hitLog)    hitTag  <= headTag;
      if (strb.searchClr) missTag <= actTag;
    end
  end

  // R7: a conflicting head never issues
  p_stall_conflict_r7: assert property (@(posedge clk) disable iff (!rstN)
    headConflict |-> !strb.issue);
  // R2: the input queue never overflows
  p_in_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inFull |-> !strb.inPush);

endmodule

// File: rtl/qdCtrl.sv
// Control: issue decision, search sequencing and active-search state.
module qdCtrl
  import qdPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      inEmpty,
  input  logic      inFull,
  input  logic      missEmpty,
  input  logic      missFull,
  input  logic      headConflict,
  input  logic      cacheHit,
  input  logic      srchDone,
  output logic      reqReady,
  output logic      cacheLookup,
  output logic      srchStart,
  output logic      activeValid,
  output qdStrobe_t strb
);
  logic canIssue;

  assign reqReady    = !inFull && !missFull;
  assign canIssue    = !inEmpty && !headConflict && !missFull;
  assign cacheLookup = canIssue;
  assign srchStart   = !activeValid && !missEmpty;

  always_comb begin
    strb           = '0;
    strb.inPush    = reqValid && reqReady;
    strb.issue     = canIssue;
    strb.missPush  = canIssue && !cacheHit;
    strb.hitLog    = canIssue && cacheHit;
    strb.missPop   = srchStart;
    strb.searchClr = srchDone && activeValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               activeValid <= 1'b0;
    else if (strb.missPop)   activeValid <= 1'b1;
    else if (strb.searchClr) activeValid <= 1'b0;
  end

  // R5: searches are serial; a start is never followed directly by another
  p_serial_search_r5: assert property (@(posedge clk) disable iff (!rstN)
    srchStart |=> !srchStart);
  // R6: the searcher only reports completion of an active search
  p_done_needs_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    srchDone |-> activeValid);

endmodule

// File: rtl/queryDispatcher.sv
module queryDispatcher
  import qdPkg::*;
#(
  parameter int IdW       = 8,
  parameter int TagW      = 4,
  parameter int InDepth   = 4,
  parameter int MissDepth = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [IdW-1:0]  reqId,
  input  logic [TagW-1:0] reqTag,
  output logic            cacheLookup,
  output logic [IdW-1:0]  cacheKey,
  input  logic            cacheHit,
  output logic            srchStart,
  output logic [IdW-1:0]  srchId,
  input  logic            srchDone,
  output logic            hitDone,
  output logic [TagW-1:0] hitTag,
  output logic            missDone,
  output logic [TagW-1:0] missTag
);
  qdStrobe_t strb;
  logic inEmpty, inFull, missEmpty, missFull, headConflict, activeValid;

  qdCtrl ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .inEmpty      (inEmpty),
    .inFull       (inFull),
    .missEmpty    (missEmpty),
    .missFull     (missFull),
    .headConflict (headConflict),
    .cacheHit     (cacheHit),
    .srchDone     (srchDone),
    .reqReady     (reqReady),
    .cacheLookup  (cacheLookup),
    .srchStart    (srchStart),
    .activeValid  (activeValid),
    .strb         (strb)
  );

  qdData #(.IdW(IdW), .TagW(TagW), .InDepth(InDepth), .MissDepth(MissDepth)) data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .activeValid  (activeValid),
    .reqId        (reqId),
    .reqTag       (reqTag),
    .inEmpty      (inEmpty),
    .inFull       (inFull),
    .missEmpty    (missEmpty),
    .missFull     (missFull),
    .headConflict (headConflict),
    .cacheKey     (cacheKey),
    .srchId       (srchId),
    .hitDone      (hitDone),
    .hitTag       (hitTag),
    .missDone     (missDone),
    .missTag      (missTag)
  );

endmodule

// File: tb/queryDispatcher_test.sv
`timescale 1ns/1ps
module queryDispatcher_test;
  localparam int IdW = 8, TagW = 4, InDepth = 4, MissDepth = 2;
  localparam int SrchLat = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, srchDone = 1'b0;
  logic [IdW-1:0] reqId = '0;
  logic [TagW-1:0] reqTag = '0;
  logic reqReady, cacheLookup, cacheHit, srchStart, hitDone, missDone;
  logic [IdW-1:0] cacheKey, srchId;
  logic [TagW-1:0] hitTag, missTag;

  logic hitMap [256];
  assign cacheHit = hitMap[cacheKey];

  always #5 clk = ~clk;

  queryDispatcher #(.IdW(IdW), .TagW(TagW), .InDepth(InDepth), .MissDepth(MissDepth)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqId(reqId), .reqTag(reqTag), .cacheLookup(cacheLookup), .cacheKey(cacheKey),
    .cacheHit(cacheHit), .srchStart(srchStart), .srchId(srchId), .srchDone(srchDone),
    .hitDone(hitDone), .hitTag(hitTag), .missDone(missDone), .missTag(missTag));

  int checks = 0, fails = 0;
  int cyc = 0, sentTotal = 0, doneTotal = 0;
  int doneCnt [16];
  int hitAt [16];
  int missAt [16];
  int expId [64];
  int expTag [64];
  int expWr = 0, expRd = 0;
  logic busy = 1'b0, monOn = 1'b0, sawNotReady = 1'b0;
  int countdown = 0, curTag = 0;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor and main-memory searcher model, both at the falling edge.
  always @(negedge clk) begin
    if (monOn) begin
      cyc++;
      if (hitDone) begin
        doneCnt[hitTag]++; hitAt[hitTag] = cyc; doneTotal++;
      end
      if (missDone) begin
        check("R6 miss completion tag", missTag == TagW'(curTag), int'(missTag), curTag);
        doneCnt[missTag]++; missAt[missTag] = cyc; doneTotal++;
      end
      if (srchDone) srchDone = 1'b0;
      else if (busy) begin
        countdown--;
        if (countdown == 0) begin srchDone = 1'b1; busy = 1'b0; end
      end
      if (srchStart) begin
        check("R5 single outstanding search", !busy && !srchDone, int'(busy), 0);
        check("R5 search order", (expRd < expWr) && (int'(srchId) == expId[expRd]),
              int'(srchId), expId[expRd]);
        curTag = expTag[expRd];
        expRd++;
        busy = 1'b1;
        countdown = SrchLat;
      end
    end
  end

  task automatic sendReq(input int id, input int tag);
    reqValid = 1'b1; reqId = IdW'(id); reqTag = TagW'(tag);
    while (!reqReady) begin sawNotReady = 1'b1; @(negedge clk); end
    @(negedge clk);
    reqValid = 1'b0;
    sentTotal++;
    if (!hitMap[id]) begin expId[expWr] = id; expTag[expWr] = tag; expWr++; end
  endtask

  task automatic clearScores();
    for (int i = 0; i < 16; i++) begin doneCnt[i] = 0; hitAt[i] = 0; missAt[i] = 0; end
    sawNotReady = 1'b0;
  endtask

  task automatic drain(input int nTags);
    int n = 0;
    while (doneTotal != sentTotal && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check("R9 all completed", doneTotal == sentTotal, doneTotal, sentTotal);
    for (int t = 0; t < nTags; t++)
      check("R9 completed exactly once", doneCnt[t] == 1, doneCnt[t], 1);
  endtask

  task automatic testReset();
    check("R1 ready after reset", reqReady == 1'b1, int'(reqReady), 1);
    check("R1 no completions", !hitDone && !missDone, int'(hitDone) + int'(missDone), 0);
    check("R1 idle outputs", !srchStart && !cacheLookup, int'(srchStart) + int'(cacheLookup), 0);
  endtask

  task automatic testHits();
    clearScores();
    sendReq(10, 0); sendReq(11, 1); sendReq(12, 2);
    drain(3);
    check("R3 back-to-back hits", hitAt[1] - hitAt[0] == 1, hitAt[1] - hitAt[0], 1);
    check("R3 hits in order", hitAt[2] - hitAt[1] == 1, hitAt[2] - hitAt[1], 1);
    check("R10 hit path only", missAt[0] == 0, missAt[0], 0);
  endtask

  task automatic testHitUnderMiss();
    clearScores();
    sendReq(20, 0); sendReq(21, 1);
    drain(2);
    check("R4 hit overtakes search", hitAt[1] < missAt[0], hitAt[1], missAt[0]);
  endtask

  task automatic testConflict();
    clearScores();
    sendReq(30, 0); sendReq(30, 1); sendReq(31, 2);
    drain(3);
    check("R7 hit behind conflict waits", hitAt[2] > missAt[0], hitAt[2], missAt[0]);
    check("R7 same id searched after first", missAt[1] > missAt[0], missAt[1], missAt[0]);
  endtask

  task automatic testMissFull();
    clearScores();
    for (int k = 0; k < 7; k++) sendReq(40 + k, k);
    sendReq(47, 7);
    check("R2 ready dropped under backlog", sawNotReady == 1'b1, int'(sawNotReady), 1);
    drain(8);
    check("R8 no issue while miss queue full", hitAt[7] > missAt[0], hitAt[7], missAt[0]);
    check("R5 searches serialized", missAt[6] > missAt[5], missAt[6], missAt[5]);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) hitMap[i] = 1'b0;
    hitMap[10] = 1'b1; hitMap[11] = 1'b1; hitMap[12] = 1'b1;
    hitMap[21] = 1'b1; hitMap[31] = 1'b1; hitMap[47] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    monOn = 1'b1;
    testHits();
    testHitUnderMiss();
    testConflict();
    testMissFull();
    finishRun();
  end
endmodule